// File: doc/BRIEF.md
# Memory Interface Reset Request Sequencer

This block sits in user logic beside one external memory interface and turns a one-cycle command from the application into a correctly shaped reset request for that interface. The interface has a calibration-done flag, and a request may only be raised while that flag is high. The request must also be a complete rise-and-fall pulse held high for at least two core clock cycles. A request that is simply left high does nothing.

When the application pulses the trigger, the sequencer goes busy. It waits until the done flag is seen high, then drives the request high for a parameterised number of cycles (never fewer than two) and drops it. It then follows the interface through its reset and recalibration by watching done fall and rise again. The time that passes between the request and the start of the reset is not fixed, so the sequencer makes no assumption about it. Busy clears only after that low-then-high handshake on done.

The done flag arrives from another timing context, so it passes through a two-flop synchronizer before the sequencer acts on it. If done fails to fall within a set number of cycles after the pulse ends, a sticky timeout flag is raised. The sequencer keeps waiting after the flag is raised.

Top module: `memif_reset_requester`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, reset_req_o, busy_o and timeout_err_o are all 0.
- R2: A one-cycle kick_i while idle makes busy_o high from the next clock edge. busy_o stays high until the sequence completes.
- R3: reset_req_o stays 0 while cal_done_i is low. If the sequencer is waiting and cal_done_i goes high, reset_req_o rises at the third rising clock edge afterwards: two synchronizer stages plus one state register.
- R4: reset_req_o stays high for exactly max(PULSE_CYCLES, 2) cycles and then returns to 0. A PULSE_CYCLES value below 2 behaves as 2.
- R5: After the pulse, busy_o remains high until the synchronized cal_done_i has been seen low and then high again. busy_o falls at the third rising edge after cal_done_i goes high in that final phase.
- R6: kick_i while busy_o is high is ignored. Each accepted kick produces exactly one request pulse.
- R7: If cal_done_i has not been seen low within FALL_TIMEOUT cycles after reset_req_o falls, timeout_err_o goes to 1. It stays 1 until reset, and the sequence still completes normally afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| kick_i | input | 1 | One-cycle command to reset the memory interface |
| cal_done_i | input | 1 | Calibration-done flag from the interface, asynchronous |
| reset_req_o | output | 1 | Reset request pulse to the interface |
| busy_o | output | 1 | High from an accepted kick until recalibration finishes |
| timeout_err_o | output | 1 | Sticky: done did not fall in time after the pulse |

## Verification
On every cycle, the assertions check four things: a request may only rise after done was seen high, a pulse never lasts a single cycle, the request never stands outside a busy period, and the timeout flag is sticky and only rises while the sequencer waits for done to fall. Some properties can only be shown by the bench's scenarios: the exact pulse widths for a clamped and an unclamped setting, the three-cycle latency from done to the request and from done to the end of busy across a sweep of done delays, that kicks are ignored mid-sequence, and where the timeout fires.

// File: rtl/memrst_pkg.sv
package memrst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_RDY  = 3'd1,
        ST_PULSE     = 3'd2,
        ST_WAIT_FALL = 3'd3,
        ST_WAIT_RISE = 3'd4
    } mr_state_e;

    function automatic int clamp_min(input int value, input int floor_v);
        return (value < floor_v) ? floor_v : value;
    endfunction

endpackage

// File: rtl/memrst_sync.sv
module memrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    localparam int N = memrst_pkg::clamp_min(STAGES, 2);

    logic [N-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[N-2:0], async_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[N-1];
endmodule

// File: rtl/memrst_seq.sv
module memrst_seq
    import memrst_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic kick_i,
    input  logic done_s_i,
    output logic req_o,
    output logic busy_o,
    output logic arm_o
);
    localparam int PW = clamp_min(PULSE_CYCLES, 2);
    localparam int CW = $clog2(PW + 1);

    typedef struct packed {
        mr_state_e      state;
        logic [CW-1:0]  cnt;
        logic           req;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (kick_i) r_d.state = ST_WAIT_RDY;
            end
            ST_WAIT_RDY: begin
                if (done_s_i) begin
                    r_d.state = ST_PULSE;
                    r_d.req   = 1'b1;
                    r_d.cnt   = '0;
                end
            end
            ST_PULSE: begin
                if (r_q.cnt == CW'(PW - 1)) begin
                    r_d.state = ST_WAIT_FALL;
                    r_d.req   = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_WAIT_FALL: begin
                if (!done_s_i) r_d.state = ST_WAIT_RISE;
            end
            ST_WAIT_RISE: begin
                if (done_s_i) r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.req   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.req   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_o  = r_q.req;
    assign busy_o = (r_q.state != ST_IDLE);
    assign arm_o  = (r_q.state == ST_WAIT_FALL);

    AST_REQ_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(r_q.req) |-> $past(done_s_i)); // R3
    AST_MIN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(r_q.req) |=> r_q.req); // R4
    AST_REQ_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.req |-> (r_q.state != ST_IDLE)); // R2
    AST_IDLE_KICK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(r_q.state) == ST_IDLE && r_q.state != ST_IDLE) |-> $past(kick_i)); // R6
endmodule

// File: rtl/memrst_fall_timer.sv
module memrst_fall_timer
    import memrst_pkg::*;
#(
    parameter int LIMIT = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    output logic err_o
);
    localparam int LIM = clamp_min(LIMIT, 1);
    localparam int TW  = $clog2(LIM + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          err;
    } tmr_reg_t;

    tmr_reg_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (arm_i) begin
            if (t_q.cnt == TW'(LIM - 1)) t_d.err = 1'b1;
            else                         t_d.cnt = t_q.cnt + 1'b1;
        end else begin
            t_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            t_q.cnt <= '0;
            t_q.err <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign err_o = t_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        t_q.err |=> t_q.err); // R7
    AST_ERR_WHILE_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(t_q.err) |-> $past(arm_i)); // R7
endmodule

// File: rtl/memif_reset_requester.sv
module memif_reset_requester #(
    parameter int PULSE_CYCLES = 4,
    parameter int FALL_TIMEOUT = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic kick_i,
    input  logic cal_done_i,
    output logic reset_req_o,
    output logic busy_o,
    output logic timeout_err_o
);
    logic done_s;
    logic arm;

    memrst_sync #(.STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(cal_done_i),
        .sync_o (done_s)
    );

    memrst_seq #(.PULSE_CYCLES(PULSE_CYCLES)) u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .kick_i  (kick_i),
        .done_s_i(done_s),
        .req_o   (reset_req_o),
        .busy_o  (busy_o),
        .arm_o   (arm)
    );

    memrst_fall_timer #(.LIMIT(FALL_TIMEOUT)) u_tmr (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .arm_i (arm),
        .err_o (timeout_err_o)
    );
endmodule

// File: tb/sim_memif_reset_requester.sv
`timescale 1ns/1ps
module sim_memif_reset_requester;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick = 1'b0;
    logic done = 1'b0;
    logic req0, busy0, err0, req1, busy1, err1;

    int checks = 0;
    int errors = 0;
    int run0 = 0, run1 = 0, width0 = 0, width1 = 0, pulses0 = 0, pulses1 = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    memif_reset_requester #(.PULSE_CYCLES(1), .FALL_TIMEOUT(TMO)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .kick_i(kick), .cal_done_i(done),
        .reset_req_o(req0), .busy_o(busy0), .timeout_err_o(err0));

    memif_reset_requester #(.PULSE_CYCLES(5), .FALL_TIMEOUT(TMO)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .kick_i(kick), .cal_done_i(done),
        .reset_req_o(req1), .busy_o(busy1), .timeout_err_o(err1));

    always @(negedge clk) begin
        if (req0) run0++;
        else if (run0 > 0) begin width0 = run0; pulses0++; run0 = 0; end
        if (req1) run1++;
        else if (run1 > 0) begin width1 = run1; pulses1++; run1 = 0; end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fire();
        kick = 1'b1;
        step(1);
        kick = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        step(3);
        chk({req0, busy0, err0, req1, busy1, err1}, 0, "R1 outputs in reset");
        rst_n = 1'b1;
        step(1);
        chk({req0, busy0, err0, req1, busy1, err1}, 0, "R1 outputs after reset");

        // accept a kick with done low: busy, but no request
        fire();
        chk({busy0, busy1}, 3, "R2 busy after kick");
        step(10);
        chk({req0, req1}, 0, "R3 no request while done low");
        chk({busy0, busy1}, 3, "R2 busy while waiting for done");

        done = 1'b1;
        step(2);
        chk({req0, req1}, 0, "R3 request not before third edge");
        step(1);
        chk({req0, req1}, 3, "R3 request at third edge");
        fire(); // R6 kick during the pulse must be ignored
        step(5);
        chk(width0, 2, "R4 clamped width");
        chk(width1, 5, "R4 programmed width");
        chk({req0, req1}, 0, "R4 request released");
        chk({busy0, busy1}, 3, "R5 busy after pulse");

        done = 1'b0;
        step(15);
        chk({busy0, busy1}, 3, "R5 busy while done low");
        chk({err0, err1}, 0, "R7 no timeout when done fell in time");
        done = 1'b1;
        step(2);
        chk({busy0, busy1}, 3, "R5 busy before done rise is seen");
        step(1);
        chk({busy0, busy1}, 0, "R5 busy clears at third edge");
        chk(pulses0, 1, "R6 one pulse u0");
        chk(pulses1, 1, "R6 one pulse u1");
        step(4);
        chk(pulses1, 1, "R6 no second pulse from ignored kick");

        // sweep the delay between the kick and done rising
        for (int d = 0; d < 6; d++) begin
            done = 1'b0;
            step(3);
            fire();
            step(d);
            done = 1'b1;
            step(2);
            chk({req0, req1}, 0, $sformatf("R3 sweep d=%0d early", d));
            step(1);
            chk({req0, req1}, 3, $sformatf("R3 sweep d=%0d rise", d));
            step(6);
            chk(width0 * 16 + width1, 2 * 16 + 5, $sformatf("R4 sweep d=%0d widths", d));
            done = 1'b0;
            step(4);
            chk({busy0, busy1}, 3, $sformatf("R5 sweep d=%0d busy", d));
            done = 1'b1;
            step(3);
            chk({busy0, busy1}, 0, $sformatf("R5 sweep d=%0d done", d));
            chk(pulses0 * 16 + pulses1, (2 + d) * 16 + (2 + d), $sformatf("R6 sweep d=%0d count", d));
        end

        // timeout: done stays high after the pulse
        fire();
        while (!req1) step(1);
        while (req1) step(1);
        step(TMO - 2);
        chk(err1, 0, "R7 no error before the limit");
        step(3);
        chk({err0, err1}, 3, "R7 error after the limit");
        chk({busy0, busy1}, 3, "R7 still waiting after the error");
        done = 1'b0;
        step(4);
        done = 1'b1;
        step(4);
        chk({busy0, busy1}, 0, "R7 sequence completes after the error");
        chk({err0, err1}, 3, "R7 error is sticky");

        finish_run();
    end
endmodule